// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Decoder

This block sits behind the descrambler of a 100 Mb/s receive path and turns a serial NRZ stream into nibbles. It takes one line bit per accepted clock, with the first bit of each 5-bit code group arriving first. While no packet is in progress it scans every bit position for the start-of-stream delimiter pair. When it finds the pair, it fixes the code-group boundaries at that point. From then on it translates each 5-bit group into a 4-bit nibble until the packet ends.

Framing is reported on a level signal, `rx_active`, that covers the whole packet. Each nibble is presented for one clock on a strobe. A packet ends cleanly on the end-of-stream pair. It ends with an error when idle arrives unannounced or when the first end delimiter is not followed by its partner. Inside a packet, any group that is not a data code is replaced by nibble 0111 and flagged.

The input is a line-rate stream with a qualifier, `line_bit_vld`, and no ready, because a recovered line cannot be paused. The output strobe likewise has no ready: the consumer must take each nibble in the cycle it is shown, which it always can, because strobes are at least four clocks apart except for the two preamble nibbles. Bits arriving while `line_bit_vld` is low are not counted.

Top module: `nrz_symbol_decoder`

## Requirements
- R1: During and after reset, and until a delimiter pair is found, `nib_vld`, `nib_err` and `rx_active` are 0 and `nib_data` is 0.
- R2: Inside a packet the sixteen data groups 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101 decode to nibbles 0x0 up to 0xF in that order, with `nib_err` low. Each group's first-received bit is its leftmost bit.
- R3: Lock happens when the last eleven accepted bits are 1 followed by J = 11000 and K = 10001. This works at any bit offset, and `rx_active` is 1 in the cycle after the clock edge that accepts the final K bit.
- R4: On lock the block presents nibble 0101 without error in the cycle after the final K bit, and 0101 again in the next cycle.
- R5: After lock, a nibble is produced exactly when the fifth accepted bit of a group is taken, one clock later. Data nibbles are therefore five clocks apart when the stream is continuous. Clocks with `line_bit_vld` low do not advance the group.
- R6: The groups 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000, 11001 and the transmit-error group H = 00100 produce nibble 0111 with `nib_err` 1, and the packet continues.
- R7: J, K, or R = 00111 arriving inside a packet without a preceding T produces nibble 0111 with `nib_err` 1, and the packet continues.
- R8: T = 01101 followed by R ends the packet cleanly. Neither group produces a nibble, and `rx_active` is 0 in the cycle after the final R bit.
- R9: Idle (11111) arriving inside a packet, not after T, produces nibble 0111 with `nib_err` 1 while `rx_active` is still 1. `rx_active` is 0 from the following cycle, and the block returns to searching.
- R10: T followed by any group other than R produces nibble 0111 with `nib_err` 1 when that group completes, and the packet ends as in R9.
- R11: A J/K pattern whose preceding bit is 0, and any bit pattern seen while searching that is not the R3 pattern, produce no nibble and leave `rx_active` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_bit | input | 1 | Descrambled NRZ line bit |
| line_bit_vld | input | 1 | Qualifies `line_bit` in this cycle |
| nib_data | output | 4 | Decoded nibble, valid while `nib_vld` is high |
| nib_vld | output | 1 | One-cycle strobe for `nib_data` |
| nib_err | output | 1 | Marks the strobed nibble as a substituted error |
| rx_active | output | 1 | High for the duration of a received packet |

## Verification
The hardest situation to reach from the ports is lock at every possible bit phase. The group counter must restart exactly on the last K bit whatever the history of the shift window. The stimulus gets there by preceding the delimiter pair with idle runs of five different lengths, so each residue modulo five is covered. It then decodes all sixteen data codes in each phase. The terminal-error paths are reached by placing idle, or T followed by a non-R group, directly after data. A following packet then shows that the search restarts cleanly.

// File: rtl/gd_pkg.sv
package gd_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;

  localparam logic [GRP_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [GRP_W-1:0] SYM_J    = 5'b11000;
  localparam logic [GRP_W-1:0] SYM_K    = 5'b10001;
  localparam logic [GRP_W-1:0] SYM_T    = 5'b01101;
  localparam logic [GRP_W-1:0] SYM_R    = 5'b00111;
  localparam logic [GRP_W-1:0] SYM_H    = 5'b00100;

  typedef enum logic [2:0] {
    SK_DATA, SK_IDLE, SK_J, SK_K, SK_T, SK_R, SK_H, SK_BAD
  } sym_kind_e;

  typedef struct packed {
    sym_kind_e        kind;
    logic [NIB_W-1:0] nib;
  } sym_t;

  typedef enum logic { FS_HUNT, FS_LOCK } fs_e;

  function automatic sym_t classify(input logic [GRP_W-1:0] g);
    sym_t s;
    s.kind = SK_DATA;
    s.nib  = '0;
    case (g)
      5'b11110: s.nib = 4'h0;
      5'b01001: s.nib = 4'h1;
      5'b10100: s.nib = 4'h2;
      5'b10101: s.nib = 4'h3;
      5'b01010: s.nib = 4'h4;
      5'b01011: s.nib = 4'h5;
      5'b01110: s.nib = 4'h6;
      5'b01111: s.nib = 4'h7;
      5'b10010: s.nib = 4'h8;
      5'b10011: s.nib = 4'h9;
      5'b10110: s.nib = 4'hA;
      5'b10111: s.nib = 4'hB;
      5'b11010: s.nib = 4'hC;
      5'b11011: s.nib = 4'hD;
      5'b11100: s.nib = 4'hE;
      5'b11101: s.nib = 4'hF;
      SYM_IDLE: s.kind = SK_IDLE;
      SYM_J:    s.kind = SK_J;
      SYM_K:    s.kind = SK_K;
      SYM_T:    s.kind = SK_T;
      SYM_R:    s.kind = SK_R;
      SYM_H:    s.kind = SK_H;
      default:  s.kind = SK_BAD;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gd_shift_window.sv
module gd_shift_window #(
  parameter int DEPTH = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [DEPTH-1:0] win_next
);
  logic [DEPTH-1:0] win_q;

  assign win_next = {win_q[DEPTH-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n)        win_q <= '0;
    else if (shift_en) win_q <= win_next;
  end
endmodule

// File: rtl/gd_sym_classify.sv
module gd_sym_classify
  import gd_pkg::*;
(
  input  logic [GRP_W-1:0] grp,
  output sym_t             sym
);
  always_comb sym = classify(grp);
endmodule

// File: rtl/gd_frame_ctrl.sv
module gd_frame_ctrl
  import gd_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] BAD_NIB = 4'h7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_valid,
  input  logic [2*GRP_W:0]     win_next,
  input  sym_t                 sym,
  output logic [NIB_W-1:0]     nib_q,
  output logic                 nib_vld_q,
  output logic                 err_q,
  output logic                 dv_q
);
  localparam int WIN_W = 2*GRP_W + 1;
  localparam int PH_W  = $clog2(GRP_W);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(GRP_W - 1);
  localparam logic [WIN_W-1:0] SYNC_PAT = {1'b1, SYM_J, SYM_K};

  fs_e              st_q, st_n;
  logic [PH_W-1:0]  ph_q, ph_n;
  logic             tseen_q, tseen_n;
  logic             pend_q, pend_n;
  logic             emit, emit_err, term;
  logic [NIB_W-1:0] emit_nib;

  always_comb begin
    st_n     = st_q;
    ph_n     = ph_q;
    tseen_n  = tseen_q;
    pend_n   = 1'b0;
    emit     = 1'b0;
    emit_err = 1'b0;
    emit_nib = '0;
    term     = 1'b0;

    if (pend_q) begin
      emit     = 1'b1;
      emit_nib = PRE_NIB;
    end

    case (st_q)
      FS_HUNT: begin
        if (bit_valid && win_next == SYNC_PAT) begin
          st_n     = FS_LOCK;
          ph_n     = '0;
          tseen_n  = 1'b0;
          pend_n   = 1'b1;
          emit     = 1'b1;
          emit_nib = PRE_NIB;
        end
      end
      default: begin
        if (bit_valid) begin
          if (ph_q == PH_LAST) begin
            ph_n = '0;
            if (tseen_q) begin
              tseen_n = 1'b0;
              st_n    = FS_HUNT;
              if (sym.kind != SK_R) begin
                emit     = 1'b1;
                emit_err = 1'b1;
                emit_nib = BAD_NIB;
                term     = 1'b1;
              end
            end else begin
              case (sym.kind)
                SK_DATA: begin
                  emit     = 1'b1;
                  emit_nib = sym.nib;
                end
                SK_T: tseen_n = 1'b1;
                SK_IDLE: begin
                  emit     = 1'b1;
                  emit_err = 1'b1;
                  emit_nib = BAD_NIB;
                  term     = 1'b1;
                  st_n     = FS_HUNT;
                end
                default: begin
                  emit     = 1'b1;
                  emit_err = 1'b1;
                  emit_nib = BAD_NIB;
                end
              endcase
            end
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= FS_HUNT;
      ph_q      <= '0;
      tseen_q   <= 1'b0;
      pend_q    <= 1'b0;
      nib_q     <= '0;
      nib_vld_q <= 1'b0;
      err_q     <= 1'b0;
      dv_q      <= 1'b0;
    end else begin
      st_q      <= st_n;
      ph_q      <= ph_n;
      tseen_q   <= tseen_n;
      pend_q    <= pend_n;
      nib_q     <= emit_nib;
      nib_vld_q <= emit;
      err_q     <= emit_err;
      dv_q      <= (st_n == FS_LOCK) || term;
    end
  end
endmodule

// File: rtl/nrz_symbol_decoder.sv
module nrz_symbol_decoder
  import gd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_bit,
  input  logic             line_bit_vld,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_vld,
  output logic             nib_err,
  output logic             rx_active
);
  localparam int WIN_W = 2*GRP_W + 1;

  logic [WIN_W-1:0] win_next;
  sym_t             grp_sym;

  gd_shift_window #(.DEPTH(WIN_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (line_bit_vld),
    .bit_in   (line_bit),
    .win_next (win_next)
  );

  gd_sym_classify u_cls (
    .grp (win_next[GRP_W-1:0]),
    .sym (grp_sym)
  );

  gd_frame_ctrl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (line_bit_vld),
    .win_next  (win_next),
    .sym       (grp_sym),
    .nib_q     (nib_data),
    .nib_vld_q (nib_vld),
    .err_q     (nib_err),
    .dv_q      (rx_active)
  );
endmodule

// File: rtl/nrz_symbol_decoder_chk.sv
module nrz_symbol_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] nib_data,
  input logic       nib_vld,
  input logic       nib_err,
  input logic       rx_active
);
  // R6/R7: an error flag only accompanies a strobed 0111
  p_err_is_subst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nib_err |-> (nib_vld && nib_data == 4'h7));

  // R11: nothing is strobed outside a packet
  p_quiet_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nib_vld |-> rx_active);

  // R4: first preamble nibble coincides with the rise of rx_active
  p_pre_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> (nib_vld && nib_data == 4'h5 && !nib_err));

  // R4: second preamble nibble on the next cycle
  p_pre_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |=> (nib_vld && nib_data == 4'h5 && !nib_err));

  // R5: adjacent strobes occur only for the preamble pair
  p_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_vld && $past(nib_vld)) |-> !$past(rx_active, 2));

  // R9: rx_active falls only after a clean end or directly after an error nibble
  p_fall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active) |-> !nib_vld);
endmodule

bind nrz_symbol_decoder nrz_symbol_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .nib_data  (nib_data),
  .nib_vld   (nib_vld),
  .nib_err   (nib_err),
  .rx_active (rx_active)
);

// File: tb/nrz_symbol_decoder_tb.sv
`timescale 1ns/1ps
module nrz_symbol_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_bit = 1'b0;
  logic       line_bit_vld = 1'b0;
  logic [3:0] nib_data;
  logic       nib_vld, nib_err, rx_active;

  always #2.5 clk = ~clk;

  nrz_symbol_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .line_bit_vld(line_bit_vld),
    .nib_data(nib_data), .nib_vld(nib_vld), .nib_err(nib_err), .rx_active(rx_active)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int last_edge = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0] ev_nib [0:63];
  logic       ev_err [0:63];
  logic       ev_dv  [0:63];
  int         ev_cyc [0:63];
  int         ev_n = 0;
  logic [3:0] ex_nib [0:63];
  logic       ex_err [0:63];
  int         ex_n = 0;

  always @(negedge clk) begin
    if (rst_n && nib_vld) begin
      if (ev_n < 64) begin
        ev_nib[ev_n] = nib_data;
        ev_err[ev_n] = nib_err;
        ev_dv[ev_n]  = rx_active;
        ev_cyc[ev_n] = cyc;
      end
      ev_n = ev_n + 1;
    end
  end

  function automatic logic [4:0] code5(input int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
     12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [4:0] badcode(input int n);
    case (n)
      0: return 5'b00000;  1: return 5'b00001;  2: return 5'b00010;  3: return 5'b00011;
      4: return 5'b00101;  5: return 5'b00110;  6: return 5'b01000;  7: return 5'b01100;
      8: return 5'b10000;  9: return 5'b11001; 10: return 5'b00100; 11: return 5'b11000;
     12: return 5'b10001; default: return 5'b00111;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic b);
    @(negedge clk);
    line_bit = b;
    line_bit_vld = 1'b1;
    @(posedge clk);
    #1;
    last_edge = cyc;
  endtask

  task automatic gap();
    @(negedge clk);
    line_bit_vld = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic grp(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) push(c[i]);
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) push(1'b1);
  endtask

  task automatic start_case();
    @(negedge clk);
    ev_n = 0;
    ex_n = 0;
  endtask

  task automatic expect_nib(input logic [3:0] n, input logic e);
    ex_nib[ex_n] = n;
    ex_err[ex_n] = e;
    ex_n++;
  endtask

  task automatic compare(input string tag);
    check(ev_n == ex_n, {tag, " nibble count"}, ev_n, ex_n);
    for (int i = 0; i < ex_n && i < ev_n && i < 64; i++) begin
      check(ev_nib[i] == ex_nib[i], {tag, " nibble value"}, ev_nib[i], ex_nib[i]);
      check(ev_err[i] == ex_err[i], {tag, " error flag"}, ev_err[i], ex_err[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int kedge;
    // R1: reset state
    repeat (4) @(posedge clk);
    #1;
    check(!nib_vld && !nib_err && !rx_active && nib_data == 4'h0, "R1 outputs in reset",
          {nib_vld, nib_err, rx_active}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: J/K preceded by a zero bit is not a lock; random search-time bits are quiet
    start_case();
    push(1'b0);
    grp(5'b11000);
    grp(5'b10001);
    check(!rx_active, "R11 no lock after zero bit", rx_active, 0);
    for (int i = 0; i < 40; i++) push(((i * 7 + 3) % 5) < 2);
    push(1'b0);
    check(!rx_active, "R11 still searching", rx_active, 0);
    compare("R11");
    check(!nib_vld && !rx_active, "R1 idle until delimiter", {nib_vld, rx_active}, 0);

    // R2/R3/R4/R5/R8: all data codes at every lock phase
    for (int off = 0; off < 5; off++) begin
      start_case();
      ones(6 + off);
      grp(5'b11000);
      grp(5'b10001);
      kedge = last_edge;
      check(rx_active == 1'b1, "R3 active after K", rx_active, 1);
      expect_nib(4'h5, 1'b0);
      expect_nib(4'h5, 1'b0);
      for (int n = 0; n < 16; n++) begin
        grp(code5(n));
        expect_nib(4'(n), 1'b0);
      end
      grp(5'b01101);
      grp(5'b00111);
      check(rx_active == 1'b0, "R8 clean end", rx_active, 0);
      ones(7);
      compare("R2");
      if (ev_n == 18) begin
        check(ev_cyc[0] == kedge, "R3 lock cycle", ev_cyc[0], kedge);
        check(ev_cyc[1] == kedge + 1, "R4 second preamble", ev_cyc[1], kedge + 1);
        check(ev_cyc[2] == kedge + 5, "R5 first data", ev_cyc[2], kedge + 5);
        for (int k = 3; k < 18; k++)
          check(ev_cyc[k] - ev_cyc[k-1] == 5, "R5 spacing", ev_cyc[k] - ev_cyc[k-1], 5);
      end
    end

    // R5: gaps in the input do not advance the group
    start_case();
    ones(6);
    grp(5'b11000);
    grp(5'b10001);
    expect_nib(4'h5, 1'b0);
    expect_nib(4'h5, 1'b0);
    for (int n = 0; n < 8; n++) begin
      logic [4:0] c;
      c = code5(n * 2 + 1);
      for (int i = 4; i >= 0; i--) begin
        push(c[i]);
        if ((i + n) % 3 == 0) gap();
      end
      expect_nib(4'(n * 2 + 1), 1'b0);
    end
    grp(5'b01101);
    grp(5'b00111);
    ones(6);
    compare("R5 stalled");

    // R6/R7: invalid, H and stray delimiter groups in the data field
    for (int b = 0; b < 14; b++) begin
      start_case();
      ones(6);
      grp(5'b11000);
      grp(5'b10001);
      grp(code5(3));
      grp(badcode(b));
      check(rx_active == 1'b1, b < 11 ? "R6 packet continues" : "R7 packet continues", rx_active, 1);
      grp(code5(9));
      grp(5'b01101);
      grp(5'b00111);
      ones(6);
      expect_nib(4'h5, 1'b0);
      expect_nib(4'h5, 1'b0);
      expect_nib(4'h3, 1'b0);
      expect_nib(4'h7, 1'b1);
      expect_nib(4'h9, 1'b0);
      compare(b < 11 ? "R6" : "R7");
    end

    // R9: idle inside a packet, then a fresh packet
    start_case();
    ones(6);
    grp(5'b11000);
    grp(5'b10001);
    grp(code5(2));
    grp(5'b11111);
    check(nib_vld && nib_err && rx_active, "R9 error nibble while active",
          {nib_vld, nib_err, rx_active}, 7);
    push(1'b1);
    check(!rx_active, "R9 active drops", rx_active, 0);
    ones(5);
    grp(5'b11000);
    grp(5'b10001);
    grp(code5(10));
    grp(5'b01101);
    grp(5'b00111);
    ones(6);
    expect_nib(4'h5, 1'b0);
    expect_nib(4'h5, 1'b0);
    expect_nib(4'h2, 1'b0);
    expect_nib(4'h7, 1'b1);
    expect_nib(4'h5, 1'b0);
    expect_nib(4'h5, 1'b0);
    expect_nib(4'hA, 1'b0);
    compare("R9");

    // R10: T followed by data, and T followed by idle
    for (int v = 0; v < 2; v++) begin
      start_case();
      ones(6);
      grp(5'b11000);
      grp(5'b10001);
      grp(code5(4));
      grp(5'b01101);
      check(!nib_vld, "R8 no nibble for T", nib_vld, 0);
      grp(v == 0 ? code5(1) : 5'b11111);
      check(nib_vld && nib_err && nib_data == 4'h7, "R10 terminal error", nib_data, 7);
      push(1'b0);
      check(!rx_active, "R10 packet ended", rx_active, 0);
      ones(12);
      expect_nib(4'h5, 1'b0);
      expect_nib(4'h5, 1'b0);
      expect_nib(4'h4, 1'b0);
      expect_nib(4'h7, 1'b1);
      compare("R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule